// File: doc/BRIEF.md
# Cross-Domain Doorbell Interrupt Register

This block holds a set of doorbell flags that two register ports share. The local host side rings a doorbell by writing ones, and each one sets the matching flag. The remote peripheral side reads the flags and writes ones back to acknowledge them, and each one clears the matching flag. While any flag is set and the enable input is high, an active-low interrupt line toward the remote side is driven low.

A test-mode input changes how the local port writes. When it is high, a local write loads the whole register with the write data, so software can set and clear any pattern for diagnostics. Both ports are single-cycle select/write-enable interfaces in one clock domain. Writes take effect at the clock edge where select and write enable are both high.

The interrupt pin comes from a two-state machine. `IRQ_IDLE` holds the pin high. `IRQ_RAISED` holds it low. The transition `IRQ_IDLE -> IRQ_RAISED` is taken at a clock edge when the registered flags are non-zero and the enable is 1. The transition `IRQ_RAISED -> IRQ_IDLE` is taken at a clock edge when the flags are all zero or the enable is 0. In every other case the machine stays in its current state.

Top module: `xdom_doorbell`

## Requirements
- R1: With test mode 0, a local write (loc_sel=1, loc_we=1) sets every flag whose loc_wdata bit is 1 and leaves flags whose bit is 0 unchanged.
- R2: A remote write (rem_sel=1, rem_we=1) clears every flag whose rem_wdata bit is 1 and leaves flags whose bit is 0 unchanged.
- R3: With test mode 1, a local write replaces all flags with loc_wdata.
- R4: irq_n is registered. At each clock edge it becomes 0 if the flags held before that edge are non-zero and irq_en is 1, and it becomes 1 otherwise. A flag write therefore reaches the pin one edge after the flags change.
- R5: Dropping irq_en leaves the flags unchanged and deasserts irq_n. Raising irq_en again reasserts irq_n if any flag is still set.
- R6: With test mode 0, when a local set and a remote clear hit the same bit in the same cycle, the bit ends at 1.
- R7: With test mode 1, a local load and a remote clear in the same cycle give loc_wdata with the remote clear mask applied afterwards.
- R8: Each port's read data equals the current flags while that port's select is 1, and equals 0 while its select is 0.
- R9: After reset all flags are 0 and irq_n is 1.
- R10: A port cycle with its select or its write enable at 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_sel | input | 1 | Local port select |
| loc_we | input | 1 | Local port write enable |
| loc_wdata | input | WIDTH | Local write data (set mask, or load value in test mode) |
| loc_rdata | output | WIDTH | Local read data |
| rem_sel | input | 1 | Remote port select |
| rem_we | input | 1 | Remote port write enable |
| rem_wdata | input | WIDTH | Remote write data (clear mask) |
| rem_rdata | output | WIDTH | Remote read data |
| irq_en | input | 1 | Doorbell interrupt enable |
| test_mode | input | 1 | Makes local writes plain loads |
| irq_n | output | 1 | Active-low interrupt toward the remote side |

## Verification
A write presented before clock edge k shows on both read ports after edge k, because the read data are combinational views of the flags. The interrupt pin reflects the flags and enable seen at edge k+1. An enable change presented before edge k shows on the pin after edge k. The bench drives every input on the falling edge and samples on the next falling edge. Its reference model records the expected pin level from the pre-edge flags and the enable driven in that cycle, and only then applies the write, so each check is aligned to the cycle in which its result is due.

// File: rtl/xdom_doorbell_pkg.sv
package xdom_doorbell_pkg;
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/db_flag_bank.sv
module db_flag_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_wr,
    input  logic             test_mode,
    input  logic [WIDTH-1:0] loc_wdata,
    input  logic             rem_wr,
    input  logic [WIDTH-1:0] rem_wdata,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] flags_next;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic set_b, clr_b;
        assign set_b = loc_wr & loc_wdata[b];
        assign clr_b = rem_wr & rem_wdata[b];
        always_comb begin
            if (loc_wr && test_mode) begin
                flags_next[b] = loc_wdata[b] & ~clr_b;
            end else begin
                flags_next[b] = (flags[b] & ~clr_b) | set_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_next;
    end

    a_r1_local_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && !test_mode) |=> ((flags & $past(loc_wdata)) == $past(loc_wdata)));
    a_r2_remote_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_wr && !loc_wr) |=> ((flags & $past(rem_wdata)) == '0));
    a_r7_test_load: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && test_mode) |=> (flags == ($past(loc_wdata) & ~($past(rem_wr) ? $past(rem_wdata) : '0))));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_wr && !rem_wr) |=> $stable(flags));
endmodule

// File: rtl/db_irq_fsm.sv
module db_irq_fsm
    import xdom_doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic irq_en,
    output logic irq_n
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending && irq_en)    state_d = IRQ_RAISED;
            IRQ_RAISED: if (!(pending && irq_en)) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != IRQ_RAISED);
    end

    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && irq_en) |=> !irq_n);
    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !pending) |=> irq_n);
endmodule

// File: rtl/xdom_doorbell.sv
module xdom_doorbell #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_sel,
    input  logic             loc_we,
    input  logic [WIDTH-1:0] loc_wdata,
    output logic [WIDTH-1:0] loc_rdata,
    input  logic             rem_sel,
    input  logic             rem_we,
    input  logic [WIDTH-1:0] rem_wdata,
    output logic [WIDTH-1:0] rem_rdata,
    input  logic             irq_en,
    input  logic             test_mode,
    output logic             irq_n
);
    logic             loc_wr, rem_wr;
    logic [WIDTH-1:0] flags;

    assign loc_wr = loc_sel & loc_we;
    assign rem_wr = rem_sel & rem_we;

    db_flag_bank #(.WIDTH(WIDTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_wr    (loc_wr),
        .test_mode (test_mode),
        .loc_wdata (loc_wdata),
        .rem_wr    (rem_wr),
        .rem_wdata (rem_wdata),
        .flags     (flags)
    );

    db_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|flags),
        .irq_en  (irq_en),
        .irq_n   (irq_n)
    );

    assign loc_rdata = loc_sel ? flags : '0;
    assign rem_rdata = rem_sel ? flags : '0;

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && rem_wr && !test_mode) |=> ((flags & $past(loc_wdata)) == $past(loc_wdata)));
    a_r8_read_match: assert property (@(posedge clk) disable iff (!rst_n)
        loc_sel |-> (loc_rdata == rem_rdata || !rem_sel));
endmodule

// File: tb/xdom_doorbell_tb.sv
module xdom_doorbell_tb;
    localparam int  W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 0, rst_n = 0;
    logic         loc_sel = 0, loc_we = 0, rem_sel = 0, rem_we = 0;
    logic         irq_en = 0, test_mode = 0;
    logic [W-1:0] loc_wdata = '0, rem_wdata = '0;
    logic [W-1:0] loc_rdata, rem_rdata;
    logic         irq_n;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [W-1:0] m = '0;
    logic         exp_irq_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdom_doorbell #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .loc_sel(loc_sel), .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .rem_sel(rem_sel), .rem_we(rem_we), .rem_wdata(rem_wdata), .rem_rdata(rem_rdata),
        .irq_en(irq_en), .test_mode(test_mode), .irq_n(irq_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, model the edge, sample at next negedge.
    task automatic step(input logic ls, lw, input logic [W-1:0] ld,
                        input logic rs, rw, input logic [W-1:0] rd,
                        input logic tm, en, input string req);
        loc_sel = ls; loc_we = lw; loc_wdata = ld;
        rem_sel = rs; rem_we = rw; rem_wdata = rd;
        test_mode = tm; irq_en = en;
        exp_irq_n = !((m != 0) && en);
        if (ls && lw && tm)       m = ld & ~((rs && rw) ? rd : '0);
        else                      m = (m & ~((rs && rw) ? rd : '0)) | ((ls && lw) ? ld : '0);
        @(posedge clk);
        @(negedge clk);
        loc_we = 0; rem_we = 0; loc_sel = 1; rem_sel = 1;
        #1;
        chk({req, " flags(local)"}, 32'(loc_rdata), 32'(m));
        chk({req, " flags(remote)"}, 32'(rem_rdata), 32'(m));
        chk({req, " irq_n"}, 32'(irq_n), 32'(exp_irq_n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        loc_sel = 1; rem_sel = 1;
        repeat (3) @(negedge clk);
        chk("R9 flags in reset", 32'(loc_rdata), 0);
        chk("R9 irq_n in reset", 32'(irq_n), 1);
        rst_n = 1;
        @(negedge clk);
        chk("R9 flags after reset", 32'(rem_rdata), 0);
        chk("R9 irq_n after reset", 32'(irq_n), 1);

        // R1 set, then R4 pin follows one edge later
        step(1, 1, 8'h05, 0, 0, 8'h00, 0, 1, "R1");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, "R4");
        step(1, 1, 8'h30, 0, 0, 8'h00, 0, 1, "R1");
        // R2 clear
        step(0, 0, 8'h00, 1, 1, 8'h14, 0, 1, "R2");
        // R5 enable drop keeps flags, re-raise reasserts
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R5");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R5");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, "R5");
        // R6 set wins
        step(1, 1, 8'h81, 1, 1, 8'h83, 0, 1, "R6");
        // R7 load then clear in test mode
        step(1, 1, 8'hF0, 1, 1, 8'h30, 1, 1, "R7");
        // R3 test mode load clears bits too
        step(1, 1, 8'h0A, 0, 0, 8'h00, 1, 1, "R3");
        // R10 writes without select or without write enable
        step(0, 1, 8'hFF, 1, 0, 8'hFF, 0, 1, "R10");
        step(1, 0, 8'hFF, 0, 1, 8'hFF, 1, 1, "R10");
        // R8 unselected ports read zero
        loc_sel = 0; rem_sel = 1; #1;
        chk("R8 local unselected", 32'(loc_rdata), 0);
        chk("R8 remote selected", 32'(rem_rdata), 32'(m));
        loc_sel = 1; rem_sel = 0; #1;
        chk("R8 remote unselected", 32'(rem_rdata), 0);
        // R2 clear all, pin returns high
        step(0, 0, 8'h00, 1, 1, 8'hFF, 0, 1, "R2");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, "R4");

        // Near-exhaustive sweep over control combinations and data patterns
        for (int i = 0; i < 1024; i++) begin
            logic tm;
            string tag;
            tm = (i % 11) == 0;
            tag = tm ? "R7 sweep" : "R6 sweep";
            step((i % 5) != 4, (i % 3) != 2, W'((i * 37 + 11) & 8'hFF),
                 (i % 7) != 6, (i % 4) == 1, W'((i * 53 + 7) & 8'hFF),
                 tm, (i % 13) != 5, tag);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule